// File: doc/BRIEF.md
# Store-Address Disambiguation Queue for a Decoupled Pipeline

This block sits between the address-computing integer pipeline of a decoupled machine, the floating-point data pipeline that runs behind it, and a single-cycle data memory. When the integer side meets a store, it pushes the store address at once. The floating-point side supplies the matching store value later, through a separate data queue. A store goes to memory only when its address and its value are both at the heads of their queues. Addresses and values are paired strictly by arrival order.

Loads are issued by the integer side. Each load address is compared with every store address that is queued and not yet written. A load that matches any of them is refused until all matching stores have reached memory. No value is forwarded from a store to a load. A load that does not match reads memory in the same cycle. Its result is pushed, together with its destination register tag, into a load result queue. The floating-point side drains that queue in program order. Several results for the same destination tag may be queued at once.

Top module: `store_disambig_queue`

## Requirements
- R1: After reset all three queues are empty: st_addr_ready and sd_ready are 1, ld_out_valid is 0, mem_wr_en is 0, and a load to any address is accepted (ld_req_ready is 1).
- R2: The store address queue holds DEPTH (8) entries. st_addr_ready is 0 exactly while 8 addresses are pending, and an offered address is then not taken.
- R3: The store data queue holds DEPTH (8) entries. sd_ready is 0 exactly while 8 values are pending.
- R4: mem_wr_en is 1 in every cycle in which both store queues are non-empty, and 0 otherwise. It writes the oldest address with the oldest value, and both are removed at that clock edge. The n-th accepted address is always paired with the n-th accepted value.
- R5: A load whose address equals any pending store address is refused (ld_req_ready is 0, mem_rd_en is 0). Pending includes the store being written in the current cycle. The load is accepted in the cycle after the last matching store is written, and it reads that store's value.
- R6: A load with no match is accepted in the same cycle when the load result queue is not full. mem_rd_en is then 1 with mem_rd_addr equal to the load address, and mem_rd_data is captured.
- R7: Load results leave in acceptance order, each carrying its own tag, and repeated tags are allowed. While ld_out_valid is 1 and ld_out_ready is 0, the head stays unchanged.
- R8: The load result queue holds DEPTH (8) entries. While it is full, ld_req_ready is 0 for every address.
- R9: A store address accepted in the same cycle as a load counts as younger than that load, so it does not block it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_addr_valid | input | 1 | Integer side offers a store address |
| st_addr | input | 16 | Store word address |
| st_addr_ready | output | 1 | Store address queue not full |
| sd_valid | input | 1 | FP side offers a store value |
| sd_data | input | 32 | Store value |
| sd_ready | output | 1 | Store data queue not full |
| ld_req_valid | input | 1 | Integer side offers a load |
| ld_req_addr | input | 16 | Load word address |
| ld_req_tag | input | 5 | FP destination register of the load |
| ld_req_ready | output | 1 | Load accepted this cycle if valid |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 32 | Memory read value, same cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 32 | Memory write value |
| ld_out_valid | output | 1 | Load result available to FP side |
| ld_out_tag | output | 5 | Destination tag of head result |
| ld_out_data | output | 32 | Value of head result |
| ld_out_ready | input | 1 | FP side takes the head result |

## Verification
On every cycle the assertions check four things. A read and a write in the same cycle never share an address. No queue is pushed while full or popped while empty. The count of live address entries matches the queue occupancy. A waiting head result does not change. The bench scenarios are what show the remaining behaviour. They show that a load is held across several matching stores and then returns the youngest value written. They show that addresses and values pair by arrival order when either side arrives first, that a store arriving with a load does not block it, and that results come out in order with repeated tags.

// File: rtl/sdaq_pkg.sv
package sdaq_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 5;
    parameter int QDEPTH = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        tag_t  tag;
        data_t data;
    } ld_result_t;

    localparam int LD_RESULT_W = $bits(ld_result_t);

    function automatic ld_result_t make_result(tag_t t, data_t d);
        ld_result_t r;
        r.tag  = t;
        r.data = d;
        return r;
    endfunction

endpackage

// File: rtl/sdaq_fifo.sv
module sdaq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R3
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R4
    AST_FIFO_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!empty && !pop) |=> $stable(head));  // R7
    AST_FIFO_FILLS: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> !empty);  // R6

endmodule

// File: rtl/sdaq_addr_cam.sv
module sdaq_addr_cam
    import sdaq_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  addr_t push_addr,
    input  logic  pop,
    input  addr_t probe_addr,
    output logic  probe_hit,
    output addr_t head_addr,
    output logic  empty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    addr_t            addr_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [DEPTH-1:0] hit_vec;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) addr_q[wr_ptr] <= push_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            live_q <= '0;
        end else begin
            if (pop) begin
                live_q[rd_ptr] <= 1'b0;
                rd_ptr         <= bump(rd_ptr);
            end
            if (push) begin
                live_q[wr_ptr] <= 1'b1;
                wr_ptr         <= bump(wr_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = live_q[g] && (addr_q[g] == probe_addr);
    end

    assign probe_hit = |hit_vec;
    assign head_addr = addr_q[rd_ptr];
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));

    AST_SAQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R2
    AST_SAQ_LIVE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(live_q) == int'(count));  // R2
    AST_SAQ_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        probe_hit |-> !empty);  // R5

endmodule

// File: rtl/store_disambig_queue.sv
module store_disambig_queue
    import sdaq_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_addr_valid,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              st_addr_ready,
    input  logic              sd_valid,
    input  logic [DATA_W-1:0] sd_data,
    output logic              sd_ready,
    input  logic              ld_req_valid,
    input  logic [ADDR_W-1:0] ld_req_addr,
    input  logic [TAG_W-1:0]  ld_req_tag,
    output logic              ld_req_ready,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              ld_out_valid,
    output logic [TAG_W-1:0]  ld_out_tag,
    output logic [DATA_W-1:0] ld_out_data,
    input  logic              ld_out_ready
);
    logic saq_push, saq_empty, saq_full, ld_hit;
    logic sdq_push, sdq_empty, sdq_full;
    logic ldq_push, ldq_pop, ldq_empty, ldq_full;
    logic st_commit, ld_fire;
    addr_t saq_head;
    logic [DATA_W-1:0]      sdq_head;
    logic [LD_RESULT_W-1:0] ldq_head;
    ld_result_t             ld_in, ld_head_s;

    // store side
    assign saq_push  = st_addr_valid && !saq_full;
    assign sdq_push  = sd_valid && !sdq_full;
    assign st_commit = !saq_empty && !sdq_empty;

    sdaq_addr_cam #(.DEPTH(DEPTH)) u_saq (
        .clk       (clk),
        .rst       (rst),
        .push      (saq_push),
        .push_addr (st_addr),
        .pop       (st_commit),
        .probe_addr(ld_req_addr),
        .probe_hit (ld_hit),
        .head_addr (saq_head),
        .empty     (saq_empty),
        .full      (saq_full)
    );

    sdaq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_sdq (
        .clk      (clk),
        .rst      (rst),
        .push     (sdq_push),
        .push_data(sd_data),
        .pop      (st_commit),
        .head     (sdq_head),
        .empty    (sdq_empty),
        .full     (sdq_full)
    );

    // load side
    assign ld_fire  = ld_req_valid && !ld_hit && !ldq_full;
    assign ld_in    = make_result(ld_req_tag, mem_rd_data);
    assign ldq_push = ld_fire;
    assign ldq_pop  = !ldq_empty && ld_out_ready;

    sdaq_fifo #(.WIDTH(LD_RESULT_W), .DEPTH(DEPTH)) u_ldq (
        .clk      (clk),
        .rst      (rst),
        .push     (ldq_push),
        .push_data(ld_in),
        .pop      (ldq_pop),
        .head     (ldq_head),
        .empty    (ldq_empty),
        .full     (ldq_full)
    );

    assign ld_head_s = ld_result_t'(ldq_head);

    // outputs
    assign st_addr_ready = !saq_full;
    assign sd_ready      = !sdq_full;
    assign ld_req_ready  = !ld_hit && !ldq_full;
    assign mem_rd_en     = ld_fire;
    assign mem_rd_addr   = ld_req_addr;
    assign mem_wr_en     = st_commit;
    assign mem_wr_addr   = saq_head;
    assign mem_wr_data   = sdq_head;
    assign ld_out_valid  = !ldq_empty;
    assign ld_out_tag    = ld_head_s.tag;
    assign ld_out_data   = ld_head_s.data;

    AST_LOAD_SAFE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mem_wr_en) |-> (mem_rd_addr != mem_wr_addr));  // R5
    AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (rst)
        (ld_req_valid && ld_req_ready) |-> mem_rd_en);  // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ld_out_valid && !ld_out_ready) |=> (ld_out_valid && $stable(ld_out_tag)
                                             && $stable(ld_out_data)));  // R7

endmodule

// File: tb/store_disambig_queue_tb.sv
module store_disambig_queue_tb;
    import sdaq_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic st_addr_valid, st_addr_ready, sd_valid, sd_ready;
    logic ld_req_valid, ld_req_ready, mem_rd_en, mem_wr_en;
    logic ld_out_valid, ld_out_ready;
    logic [ADDR_W-1:0] st_addr, ld_req_addr, mem_rd_addr, mem_wr_addr;
    logic [DATA_W-1:0] sd_data, mem_rd_data, mem_wr_data, ld_out_data;
    logic [TAG_W-1:0]  ld_req_tag, ld_out_tag;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [DATA_W-1:0] mem [256];

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= DATA_W'(i * 3 + 7);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr[7:0]] <= mem_wr_data;
        end
    end
    assign mem_rd_data = mem[mem_rd_addr[7:0]];

    store_disambig_queue u_dut (
        .clk(clk), .rst(rst),
        .st_addr_valid(st_addr_valid), .st_addr(st_addr), .st_addr_ready(st_addr_ready),
        .sd_valid(sd_valid), .sd_data(sd_data), .sd_ready(sd_ready),
        .ld_req_valid(ld_req_valid), .ld_req_addr(ld_req_addr), .ld_req_tag(ld_req_tag),
        .ld_req_ready(ld_req_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .ld_out_valid(ld_out_valid), .ld_out_tag(ld_out_tag), .ld_out_data(ld_out_data),
        .ld_out_ready(ld_out_ready)
    );

    function automatic logic [DATA_W-1:0] init_val(int a);
        return DATA_W'(a * 3 + 7);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pop_check(string req, logic [TAG_W-1:0] tag, logic [DATA_W-1:0] data);
        ld_out_ready = 1'b1;
        #1;
        check({req, " valid"}, 32'(ld_out_valid), 32'd1);
        check({req, " tag"}, 32'(ld_out_tag), 32'(tag));
        check({req, " data"}, ld_out_data, data);
        tick();
        ld_out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        st_addr_valid = 0; st_addr = '0; sd_valid = 0; sd_data = '0;
        ld_req_valid = 0; ld_req_addr = '0; ld_req_tag = '0; ld_out_ready = 0;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 st_addr_ready", 32'(st_addr_ready), 1);
        check("R1 sd_ready", 32'(sd_ready), 1);
        check("R1 ld_out_valid", 32'(ld_out_valid), 0);
        check("R1 mem_wr_en", 32'(mem_wr_en), 0);
        check("R1 ld_req_ready", 32'(ld_req_ready), 1);

        // R6 / R8 / R7: sweep loads with no stores, two fill-and-drain rounds
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 8; i++) begin
                ld_req_valid = 1; ld_req_addr = ADDR_W'(r * 8 + i + 1);
                ld_req_tag = TAG_W'(i % 3);
                #1;
                check("R6 ready", 32'(ld_req_ready), 1);
                check("R6 rd_en", 32'(mem_rd_en), 1);
                check("R6 rd_addr", 32'(mem_rd_addr), 32'(r * 8 + i + 1));
                tick();
            end
            ld_req_addr = 16'h30;
            #1;
            check("R8 ready when full", 32'(ld_req_ready), 0);
            check("R8 no read when full", 32'(mem_rd_en), 0);
            ld_req_valid = 0;
            for (int i = 0; i < 8; i++)
                pop_check("R7", TAG_W'(i % 3), init_val(r * 8 + i + 1));
            #1;
            check("R7 drained", 32'(ld_out_valid), 0);
        end

        // R2: fill the store address queue
        for (int i = 0; i < 8; i++) begin
            st_addr_valid = 1; st_addr = ADDR_W'(16'h40 + 4 * i);
            #1;
            check("R2 ready", 32'(st_addr_ready), 1);
            tick();
        end
        st_addr = 16'h60;
        #1;
        check("R2 full", 32'(st_addr_ready), 0);
        check("R4 no data no write", 32'(mem_wr_en), 0);
        st_addr_valid = 0;

        // R5: every pending address blocks, a non-matching one passes
        ld_req_valid = 1; ld_req_tag = 5'd4;
        for (int i = 0; i < 8; i++) begin
            ld_req_addr = ADDR_W'(16'h40 + 4 * i);
            #1;
            check("R5 blocked", 32'(ld_req_ready), 0);
            check("R5 no read", 32'(mem_rd_en), 0);
        end
        ld_req_addr = 16'h42;
        #1;
        check("R6 non-match", 32'(ld_req_ready), 1);
        tick();
        ld_req_valid = 0;
        pop_check("R6", 5'd4, init_val(16'h42));

        // R4: values arrive one by one, writes in order
        for (int i = 0; i < 8; i++) begin
            sd_valid = 1; sd_data = 32'hD000 + 32'(i);
            #1;
            check("R4 data queue empty", 32'(mem_wr_en), 0);
            tick();
            sd_valid = 0;
            #1;
            check("R4 wr_en", 32'(mem_wr_en), 1);
            check("R4 wr_addr", 32'(mem_wr_addr), 32'(16'h40 + 4 * i));
            check("R4 wr_data", mem_wr_data, 32'hD000 + 32'(i));
            if (i == 2) begin
                ld_req_valid = 1; ld_req_addr = 16'h48; ld_req_tag = 5'd7;
                #1;
                check("R5 head being written", 32'(ld_req_ready), 0);
            end
            tick();
            check("R4 one write per pair", 32'(mem_wr_en), 0);
            if (i == 2) begin
                check("R5 released", 32'(ld_req_ready), 1);
                check("R5 read", 32'(mem_rd_en), 1);
                tick();
                ld_req_valid = 0;
            end
        end
        check("R2 drained", 32'(st_addr_ready), 1);
        pop_check("R5 new value", 5'd7, 32'hD002);

        // R5: two pending stores to one address
        st_addr_valid = 1; st_addr = 16'h80;
        tick(); tick();
        st_addr_valid = 0;
        sd_valid = 1; sd_data = 32'hE1;
        tick();
        sd_valid = 0;
        #1;
        check("R4 first dup write", mem_wr_data, 32'hE1);
        ld_req_valid = 1; ld_req_addr = 16'h80; ld_req_tag = 5'd2;
        #1;
        check("R5 two pending", 32'(ld_req_ready), 0);
        tick();
        check("R5 one pending", 32'(ld_req_ready), 0);
        check("R4 no data", 32'(mem_wr_en), 0);
        sd_valid = 1; sd_data = 32'hE2;
        tick();
        sd_valid = 0;
        #1;
        check("R4 second dup write", mem_wr_data, 32'hE2);
        check("R5 last pending", 32'(ld_req_ready), 0);
        tick();
        check("R5 dup released", 32'(ld_req_ready), 1);
        tick();
        ld_req_valid = 0;
        pop_check("R5 youngest value", 5'd2, 32'hE2);

        // R9: store address and load in the same cycle
        st_addr_valid = 1; st_addr = 16'h90;
        ld_req_valid = 1; ld_req_addr = 16'h90; ld_req_tag = 5'd9;
        #1;
        check("R9 same-cycle load", 32'(ld_req_ready), 1);
        tick();
        st_addr_valid = 0;
        #1;
        check("R5 now pending", 32'(ld_req_ready), 0);
        ld_req_valid = 0;
        pop_check("R9 old value", 5'd9, init_val(16'h90));
        sd_valid = 1; sd_data = 32'h99;
        tick();
        sd_valid = 0;
        #1;
        check("R4 wr_addr", 32'(mem_wr_addr), 32'h90);
        tick();

        // R3: values before addresses
        for (int i = 0; i < 8; i++) begin
            sd_valid = 1; sd_data = 32'hF00 + 32'(i);
            #1;
            check("R3 ready", 32'(sd_ready), 1);
            check("R4 no address", 32'(mem_wr_en), 0);
            tick();
        end
        sd_data = 32'hF99;
        #1;
        check("R3 full", 32'(sd_ready), 0);
        sd_valid = 0;
        for (int i = 0; i < 9; i++) begin
            st_addr_valid = (i < 8); st_addr = ADDR_W'(16'hA0 + 4 * i);
            #1;
            if (i > 0) begin
                check("R4 streaming addr", 32'(mem_wr_addr), 32'(16'hA0 + 4 * (i - 1)));
                check("R4 streaming data", mem_wr_data, 32'hF00 + 32'(i - 1));
            end
            tick();
        end
        st_addr_valid = 0;
        #1;
        check("R4 idle", 32'(mem_wr_en), 0);
        check("R3 drained", 32'(sd_ready), 1);
        ld_req_valid = 1; ld_req_addr = 16'hA4; ld_req_tag = 5'd1;
        tick();
        ld_req_valid = 0;
        pop_check("R4 memory content", 5'd1, 32'hF01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule